// File: doc/BRIEF.md
# Dual-Channel Frequency-Change Sequencer

This block coordinates a clock-frequency change for a memory controller that drives two PHY channels in lock-step. A single request raises a start handshake on both channels at once. Each channel answers by pulling its init-complete line low. The block then either runs the switch or abandons it. If both channels answer, it pulses a clock-switch enable for a fixed settling time, loads the new frequency ratio and drops the start lines. It reports done once both channels are back up.

If only one channel answers inside a programmable window, the change is cancelled. Both start lines drop, the clock-switch enable stays low and the ratio keeps its old value. The block then waits until the answering channel has raised its init-complete again, and only then reports the abort. A command-block output holds off all traffic on both channels for the whole sequence. A separate ready output tells the controller when both channels report initialization complete.

Top module: `dual_freq_seq`

## Requirements
- R1: After reset the start lines, clock-switch enable, busy, command block, done and aborted are all low, and the ratio output equals INIT_RATIO. The ready output goes high one cycle after both init-complete inputs are high and is low otherwise (bit 0 is channel 0, bit 1 is channel 1).
- R2: A request seen while idle raises both start lines together on the next cycle. On that same cycle busy and the command block go high, done and aborted are cleared, and the requested ratio is captured.
- R3: A channel acknowledges when its init-complete input is low during the acknowledge phase. The phase lasts `ack_window` cycles, and a value of 0 acts as 1. A channel that stays high for the whole phase has not acknowledged.
- R4: Once both channels have acknowledged, the clock-switch enable rises on the next cycle and stays high for exactly SETTLE cycles. On the cycle it falls, the ratio output takes the captured value and both start lines drop.
- R5: After a switch, done is set, and busy and the command block are released, one cycle after both init-complete inputs are high.
- R6: If exactly one channel acknowledges, both start lines drop when the window expires. The clock-switch enable never rises in that sequence, and the ratio output keeps its previous value.
- R7: After a split response, the command block stays high until the acknowledging channel's init-complete is high again. One cycle later, aborted is set and the command block is released in that same cycle.
- R8: If neither channel acknowledges, both start lines drop at expiry and aborted is set on the following cycle.
- R9: A request that arrives while a sequence is active is ignored. Busy stays high and the captured ratio is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_req | input | 1 | Frequency-change request |
| fc_ratio_in | input | RATIO_W | Target frequency ratio |
| ack_window | input | WIN_W | Acknowledge window length in cycles |
| ch_init_done | input | 2 | Per-channel init-complete |
| ch_init_start | output | 2 | Per-channel init-start |
| freq_ratio | output | RATIO_W | Ratio value driven to both channels |
| clk_switch_en | output | 1 | Clock-switch enable |
| cmd_block | output | 1 | Holds off command issue on both channels |
| init_ready | output | 1 | Both channels report init complete |
| busy | output | 1 | Sequence in progress |
| fc_done | output | 1 | Last sequence switched the clock |
| fc_aborted | output | 1 | Last sequence was cancelled |

## Verification
The inline assertions check several things on every cycle. Both start lines rise together. The command block covers the whole of busy. The clock-switch enable is only high while both start lines are up. The ratio changes only as the enable falls. Done appears only after both channels were seen high. Acknowledge flags stay set until cleared.

Other behaviour depends on ordered stimulus, so only the bench scenarios can show it. That includes which of both, one or neither channels answered, a window of zero, a request arriving mid-sequence, and how long an abort waits for the answering channel to recover. The bench's cycle model covers these cases.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SWITCH,
    ST_RELEASE,
    ST_CANCEL
  } seq_state_t;
endpackage

// File: rtl/dfs_counter.sv
module dfs_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dfs_ack_track.sv
module dfs_ack_track (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample,
  input  logic init_done,
  output logic acked,
  output logic ack_now
);
  assign ack_now = acked | (sample & ~init_done);

  always_ff @(posedge clk) begin
    if (rst || clr) acked <= 1'b0;
    else            acked <= ack_now;
  end

  // R3: an acknowledge, once seen, is held until the next sequence starts
  a_r3_ack_sticky: assert property (@(posedge clk) disable iff (rst)
    (acked && !clr) |=> acked);
endmodule

// File: rtl/dual_freq_seq.sv
module dual_freq_seq
  import dfs_pkg::*;
#(
  parameter int RATIO_W    = 2,
  parameter int WIN_W      = 8,
  parameter int SETTLE     = 4,
  parameter int INIT_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fc_req,
  input  logic [RATIO_W-1:0] fc_ratio_in,
  input  logic [WIN_W-1:0]   ack_window,
  input  logic [1:0]         ch_init_done,
  output logic [1:0]         ch_init_start,
  output logic [RATIO_W-1:0] freq_ratio,
  output logic               clk_switch_en,
  output logic               cmd_block,
  output logic               init_ready,
  output logic               busy,
  output logic               fc_done,
  output logic               fc_aborted
);
  localparam int SET_W = $clog2(SETTLE + 1);

  seq_state_t         st;
  logic [RATIO_W-1:0] tgt_ratio;
  logic [NUM_CH-1:0]  acked, ack_now;
  logic [WIN_W-1:0]   win_cnt;
  logic [SET_W-1:0]   set_cnt;
  logic               in_wait, win_expired, settle_end, cancel_ok;

  assign in_wait = (st == ST_WAIT);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
    dfs_ack_track u_ack (
      .clk      (clk),
      .rst      (rst),
      .clr      (st == ST_IDLE),
      .sample   (in_wait),
      .init_done(ch_init_done[g]),
      .acked    (acked[g]),
      .ack_now  (ack_now[g])
    );
  end

  dfs_counter #(.W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .clr(!in_wait), .en(in_wait), .cnt(win_cnt)
  );

  dfs_counter #(.W(SET_W)) u_settle (
    .clk(clk), .rst(rst), .clr(st != ST_SWITCH), .en(st == ST_SWITCH), .cnt(set_cnt)
  );

  assign win_expired = ({1'b0, win_cnt} + 1'b1) >= {1'b0, ack_window};
  assign settle_end  = (set_cnt == SET_W'(SETTLE - 1));
  assign cancel_ok   = &(ch_init_done | ~acked);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      tgt_ratio     <= RATIO_W'(INIT_RATIO);
      freq_ratio    <= RATIO_W'(INIT_RATIO);
      ch_init_start <= '0;
      clk_switch_en <= 1'b0;
      cmd_block     <= 1'b0;
      busy          <= 1'b0;
      fc_done       <= 1'b0;
      fc_aborted    <= 1'b0;
      init_ready    <= 1'b0;
    end else begin
      init_ready <= &ch_init_done;
      case (st)
        ST_IDLE: if (fc_req) begin
          st            <= ST_WAIT;
          tgt_ratio     <= fc_ratio_in;
          ch_init_start <= '1;
          busy          <= 1'b1;
          cmd_block     <= 1'b1;
          fc_done       <= 1'b0;
          fc_aborted    <= 1'b0;
        end
        ST_WAIT: begin
          if (&ack_now) begin
            st            <= ST_SWITCH;
            clk_switch_en <= 1'b1;
          end else if (win_expired) begin
            st            <= ST_CANCEL;
            ch_init_start <= '0;
          end
        end
        ST_SWITCH: if (settle_end) begin
          st            <= ST_RELEASE;
          clk_switch_en <= 1'b0;
          freq_ratio    <= tgt_ratio;
          ch_init_start <= '0;
        end
        ST_RELEASE: if (&ch_init_done) begin
          st        <= ST_IDLE;
          fc_done   <= 1'b1;
          busy      <= 1'b0;
          cmd_block <= 1'b0;
        end
        ST_CANCEL: if (cancel_ok) begin
          st         <= ST_IDLE;
          fc_aborted <= 1'b1;
          busy       <= 1'b0;
          cmd_block  <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: both channels are started in the same cycle
  a_r2_start_together: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ch_init_start == 2'b11));
  // R7: commands are held off for the whole sequence
  a_r7_block_covers_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> cmd_block);
  // R6: the clock may switch only while both channels stay in the handshake
  a_r6_switch_needs_both: assert property (@(posedge clk) disable iff (rst)
    clk_switch_en |-> (ch_init_start == 2'b11));
  // R4: the shared ratio moves only as the switch enable ends
  a_r4_ratio_at_switch_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_ratio) |-> $fell(clk_switch_en));
  // R5: done follows both channels being seen complete
  a_r5_done_after_both: assert property (@(posedge clk) disable iff (rst)
    $rose(fc_done) |-> $past(&ch_init_done));
  // R9: captured target is frozen during a sequence
  a_r9_target_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(tgt_ratio));
endmodule

// File: tb/test_dual_freq_seq.sv
module test_dual_freq_seq;
  localparam int RW = 2, WW = 8, SETTLE = 4, INIT_RATIO = 1;

  logic          clk = 1'b0, rst = 1'b1;
  logic          fc_req = 1'b0;
  logic [RW-1:0] fc_ratio_in = '0;
  logic [WW-1:0] ack_window = 8'd6;
  logic [1:0]    ch_init_done = 2'b11;
  logic [1:0]    ch_init_start;
  logic [RW-1:0] freq_ratio;
  logic clk_switch_en, cmd_block, init_ready, busy, fc_done, fc_aborted;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_en = 0, sw_seen = 0;

  dual_freq_seq #(.RATIO_W(RW), .WIN_W(WW), .SETTLE(SETTLE), .INIT_RATIO(INIT_RATIO)) i_dual_freq_seq (
    .clk(clk), .rst(rst), .fc_req(fc_req), .fc_ratio_in(fc_ratio_in),
    .ack_window(ack_window), .ch_init_done(ch_init_done),
    .ch_init_start(ch_init_start), .freq_ratio(freq_ratio),
    .clk_switch_en(clk_switch_en), .cmd_block(cmd_block), .init_ready(init_ready),
    .busy(busy), .fc_done(fc_done), .fc_aborted(fc_aborted));

  always #10 clk = ~clk;

  // behavioural reference: phase 0 idle, 1 listen, 2 switching, 3 waiting up, 4 cancelling
  int phase = 0, cnt = 0, win;
  bit [1:0] heard = 0, m_start = 0;
  int m_ratio = INIT_RATIO, m_tgt = INIT_RATIO;
  bit m_sw = 0, m_block = 0, m_ready = 0, m_busy = 0, m_done = 0, m_abort = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; cnt = 0; heard = 0; m_start = 0; m_ratio = INIT_RATIO; m_tgt = INIT_RATIO;
      m_sw = 0; m_block = 0; m_ready = 0; m_busy = 0; m_done = 0; m_abort = 0;
    end else begin
      bit [1:0] now;
      m_ready = (ch_init_done == 2'b11);
      win = (ack_window == 0) ? 1 : int'(ack_window);
      if (phase == 0) begin
        if (fc_req) begin
          phase = 1; cnt = 0; heard = 0; m_start = 2'b11; m_tgt = fc_ratio_in;
          m_busy = 1; m_block = 1; m_done = 0; m_abort = 0;
        end
      end else if (phase == 1) begin
        now = heard | ~ch_init_done;
        cnt++;
        if (now == 2'b11) begin phase = 2; cnt = 0; m_sw = 1; end
        else if (cnt >= win) begin phase = 4; m_start = 0; end
        heard = now;
      end else if (phase == 2) begin
        cnt++;
        if (cnt == SETTLE) begin phase = 3; m_sw = 0; m_ratio = m_tgt; m_start = 0; end
      end else if (phase == 3) begin
        if (ch_init_done == 2'b11) begin phase = 0; m_done = 1; m_busy = 0; m_block = 0; end
      end else begin
        if ((ch_init_done | ~heard) == 2'b11) begin phase = 0; m_abort = 1; m_busy = 0; m_block = 0; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (clk_switch_en) sw_seen = 1;
    if (cmp_en) begin
      chk("R1 init_ready", init_ready, m_ready);
      chk("R2 ch_init_start", ch_init_start, m_start);
      chk("R4 clk_switch_en", clk_switch_en, m_sw);
      chk("R4 freq_ratio", freq_ratio, m_ratio);
      chk("R5 fc_done", fc_done, m_done);
      chk("R6 fc_aborted", fc_aborted, m_abort);
      chk("R7 cmd_block", cmd_block, m_block);
      chk("R9 busy", busy, m_busy);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic r, input logic [RW-1:0] rat, input logic [1:0] d);
    @(negedge clk);
    fc_req = r; fc_ratio_in = rat; ch_init_done = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmp_en = 1;
    #1;
    chk("R1 reset start", ch_init_start, 0);
    chk("R1 reset ratio", freq_ratio, INIT_RATIO);
    @(negedge clk); rst = 0;
    repeat (2) step(0, 0, 2'b11);
    chk("R1 ready both high", init_ready, 1);

    // both acknowledge, second request mid-sequence
    step(1, 2, 2'b11);
    chk("R2 both started", ch_init_start, 3);
    step(0, 0, 2'b11);
    step(0, 0, 2'b10);
    step(1, 3, 2'b00);
    chk("R9 busy on second request", busy, 1);
    repeat (8) step(0, 0, 2'b00);
    repeat (3) step(0, 0, 2'b11);
    chk("R4 ratio switched", freq_ratio, 2);
    chk("R5 done", fc_done, 1);
    chk("R9 later request ignored", freq_ratio == 3, 0);

    // split: only channel 1 answers
    sw_seen = 0;
    step(1, 3, 2'b11);
    repeat (9) step(0, 0, 2'b01);
    chk("R7 block held during cancel", cmd_block, 1);
    chk("R6 starts dropped", ch_init_start, 0);
    repeat (2) step(0, 0, 2'b11);
    chk("R6 aborted", fc_aborted, 1);
    chk("R6 ratio unchanged", freq_ratio, 2);
    chk("R6 no switch", sw_seen, 0);

    // neither answers
    step(1, 1, 2'b11);
    repeat (8) step(0, 0, 2'b11);
    chk("R8 silent abort", fc_aborted, 1);
    chk("R8 ratio unchanged", freq_ratio, 2);

    // zero window treated as one cycle
    ack_window = 0;
    step(1, 1, 2'b11);
    step(0, 0, 2'b10);
    step(0, 0, 2'b10);
    chk("R7 abort waits for channel", fc_aborted, 0);
    repeat (2) step(0, 0, 2'b11);
    chk("R3 zero window abort", fc_aborted, 1);

    // both acknowledge, channel 1 first
    ack_window = 6;
    step(1, 0, 2'b11);
    step(0, 0, 2'b01);
    step(0, 0, 2'b00);
    repeat (7) step(0, 0, 2'b00);
    repeat (2) step(0, 0, 2'b11);
    chk("R4 ratio switched to 0", freq_ratio, 0);
    chk("R5 done again", fc_done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule